// File: doc/BRIEF.md
# Key-Protected Pipelined Parameter RAM

This block holds a small set of 28-bit calibration and configuration words that a running computation engine reads, mapped onto a fixed window of a register bus from 0x4380 up to and including 0x43BE (63 locations). A bus write aimed at the window does not go straight into storage. It enters a two-deep write pipeline, and each later accepted window write pushes the pipeline one step. A value therefore reaches the storage only when two further window writes have arrived after it. Software that sets a single word has to follow it with two more writes, for example by writing the same word again twice.

A keyed lock guards the window. Writing the key byte to one special address arms the lock logic. The write that comes right after it then selects the action: a command byte to a second special address turns protection on or off. While protection is on, window writes are dropped. Reads of the window are always served from storage, and storage may be changed while the engine keeps running.

Top module: `keyed_param_ram`

## Requirements
- R1: The window is 0x4380..0x43BE (63 locations of 28 bits). A read addressed outside the window returns 0.
- R2: After reset every window location reads 0 and protection is off, so window writes are accepted.
- R3: An accepted window write is stored only on the clock edge of the second accepted window write that follows it. Bus writes to addresses outside the window (including the key and command addresses) neither enter nor advance the pipeline.
- R4: A read of a location whose write is still waiting in the pipeline returns the old stored contents.
- R5: Writing low byte 0xAD to 0xE7FE and, as the very next write, low byte 0x80 to 0xE7E3 turns protection on.
- R6: Writing low byte 0xAD to 0xE7FE and, as the very next write, low byte 0x00 to 0xE7E3 turns protection off.
- R7: While protection is on, window writes are discarded. They do not enter the pipeline, and they do not advance it, so words already pending stay pending.
- R8: Reads of the window return stored data whatever the protection state.
- R9: The key arms only the next bus write. Any other intervening write, a wrong key byte, or a command byte other than 0x80 or 0x00 leaves protection unchanged and disarms the key. Idle cycles between key and command do not disarm it.
- R10: Only bits 27:0 of write data are stored. rd_data is the stored word zero-extended to 32 bits, and it is 0 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 16 | Bus read address |
| rd_data | output | 32 | Read data, combinational from rd_addr and rd_en |

## Verification
The assertions check on every cycle the following points. A locked window write never commits and never changes the pipeline fill. Protection changes only on a command write that directly follows an armed key. Any non-key write clears the arm. The pipeline fills in order, and the upper read bits stay zero. Only the bench scenarios can show the data path end to end: a value appears exactly at the second following write, pending reads return old data, and rejected writes leave pending words held until unlock. The bench also shows that each malformed key sequence leaves the lock engaged, as seen through later reads.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic {
    LK_IDLE  = 1'b0,
    LK_ARMED = 1'b1
  } lk_state_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2
  } lk_cmd_e;

  // Inclusive address span test, all operands widened to 32 bits.
  function automatic logic in_span(input logic [31:0] a,
                                   input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Offset of an address from the window base.
  function automatic logic [31:0] span_offset(input logic [31:0] a,
                                              input logic [31:0] lo);
    return a - lo;
  endfunction

  // Classify a command byte.
  function automatic lk_cmd_e decode_cmd(input logic [7:0] b,
                                         input logic [7:0] on_v,
                                         input logic [7:0] off_v);
    if (b == on_v)  return CMD_LOCK;
    if (b == off_v) return CMD_UNLOCK;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/ppr_lock.sv
module ppr_lock
  import ppr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hE7FE,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hE7E3,
  parameter logic [7:0]        KEY_VAL  = 8'hAD,
  parameter logic [7:0]        CMD_ON   = 8'h80,
  parameter logic [7:0]        CMD_OFF  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  output logic              prot_on,
  output logic              key_armed
);

  lk_state_e st_q;
  logic      key_hit;
  logic      cmd_hit;
  lk_cmd_e   cmd;

  assign key_hit = wr_en && (wr_addr == KEY_ADDR) && (wr_byte == KEY_VAL);
  assign cmd_hit = wr_en && (st_q == LK_ARMED) && (wr_addr == CMD_ADDR);
  assign cmd     = decode_cmd(wr_byte, CMD_ON, CMD_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      prot_on <= 1'b0;
    end else if (wr_en) begin
      if (key_hit) begin
        st_q <= LK_ARMED;
      end else begin
        st_q <= LK_IDLE;
        if (cmd_hit) begin
          case (cmd)
            CMD_LOCK:   prot_on <= 1'b1;
            CMD_UNLOCK: prot_on <= 1'b0;
            default:    prot_on <= prot_on;
          endcase
        end
      end
    end
  end

  assign key_armed = (st_q == LK_ARMED);

endmodule

// File: rtl/ppr_wpipe.sv
module ppr_wpipe #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 28,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [DATA_W-1:0] push_data,
  output logic              commit_en,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data,
  output logic [STAGES-1:0] stage_valid
);

  logic [IDX_W-1:0]  st_idx  [STAGES];
  logic [DATA_W-1:0] st_data [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic              src_v;
    logic [IDX_W-1:0]  src_i;
    logic [DATA_W-1:0] src_d;
    logic              v_q;
    logic [IDX_W-1:0]  i_q;
    logic [DATA_W-1:0] d_q;

    if (g == 0) begin : g_head
      assign src_v = 1'b1;
      assign src_i = push_idx;
      assign src_d = push_data;
    end else begin : g_tail
      assign src_v = stage_valid[g-1];
      assign src_i = st_idx[g-1];
      assign src_d = st_data[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        i_q <= '0;
        d_q <= '0;
      end else if (push) begin
        v_q <= src_v;
        i_q <= src_i;
        d_q <= src_d;
      end
    end

    assign stage_valid[g] = v_q;
    assign st_idx[g]      = i_q;
    assign st_data[g]     = d_q;
  end

  assign commit_en   = push && stage_valid[STAGES-1];
  assign commit_idx  = st_idx[STAGES-1];
  assign commit_data = st_data[STAGES-1];

endmodule

// File: rtl/ppr_array.sv
module ppr_array #(
  parameter int DEPTH  = 63,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              w_ok;
  logic              r_ok;

  assign w_ok = (32'(widx) < DEPTH);
  assign r_ok = (32'(ridx) < DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && w_ok) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = r_ok ? mem[ridx] : '0;

endmodule

// File: rtl/keyed_param_ram.sv
module keyed_param_ram
  import ppr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                BUS_W    = 32,
  parameter int                DATA_W   = 28,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4380,
  parameter logic [ADDR_W-1:0] WIN_LAST = 16'h43BE,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hE7FE,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hE7E3,
  parameter logic [7:0]        KEY_VAL  = 8'hAD,
  parameter logic [7:0]        CMD_ON   = 8'h80,
  parameter logic [7:0]        CMD_OFF  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data
);

  localparam int DEPTH  = int'(WIN_LAST) - int'(WIN_BASE) + 1;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int STAGES = 2;

  // Named internal events used by the checker.
  logic              win_wr;
  logic              win_rd;
  logic              wr_accept;
  logic              prot_on;
  logic              key_armed;
  logic              commit_en;
  logic [IDX_W-1:0]  commit_idx;
  logic [DATA_W-1:0] commit_data;
  logic [STAGES-1:0] stage_valid;
  logic [31:0]       wr_off;
  logic [31:0]       rd_off;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] arr_rdata;

  assign win_wr    = in_span(32'(wr_addr), 32'(WIN_BASE), 32'(WIN_LAST));
  assign win_rd    = in_span(32'(rd_addr), 32'(WIN_BASE), 32'(WIN_LAST));
  assign wr_off    = span_offset(32'(wr_addr), 32'(WIN_BASE));
  assign rd_off    = span_offset(32'(rd_addr), 32'(WIN_BASE));
  assign wr_idx    = wr_off[IDX_W-1:0];
  assign rd_idx    = rd_off[IDX_W-1:0];
  assign wr_accept = wr_en && win_wr && !prot_on;

  ppr_lock #(
    .ADDR_W  (ADDR_W),
    .KEY_ADDR(KEY_ADDR),
    .CMD_ADDR(CMD_ADDR),
    .KEY_VAL (KEY_VAL),
    .CMD_ON  (CMD_ON),
    .CMD_OFF (CMD_OFF)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_byte  (wr_data[7:0]),
    .prot_on  (prot_on),
    .key_armed(key_armed)
  );

  ppr_wpipe #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .STAGES(STAGES)
  ) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_accept),
    .push_idx   (wr_idx),
    .push_data  (wr_data[DATA_W-1:0]),
    .commit_en  (commit_en),
    .commit_idx (commit_idx),
    .commit_data(commit_data),
    .stage_valid(stage_valid)
  );

  ppr_array #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit_en),
    .widx (commit_idx),
    .wdata(commit_data),
    .ridx (rd_idx),
    .rdata(arr_rdata)
  );

  assign rd_data = (rd_en && win_rd) ? BUS_W'(arr_rdata) : '0;

endmodule

// File: rtl/ppr_chk.sv
module ppr_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                BUS_W    = 32,
  parameter int                DATA_W   = 28,
  parameter int                STAGES   = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hE7FE,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hE7E3,
  parameter logic [7:0]        KEY_VAL  = 8'hAD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_byte,
  input logic [BUS_W-1:0]  rd_data,
  input logic              win_wr,
  input logic              prot_on,
  input logic              key_armed,
  input logic              commit_en,
  input logic [STAGES-1:0] stage_valid
);

  AST_LOCKED_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_wr && prot_on) |-> !commit_en); // R7

  AST_LOCKED_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_wr && prot_on) |=> $stable(stage_valid)); // R7

  AST_COMMIT_ON_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (wr_en && win_wr)); // R3

  AST_FILL_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_valid[STAGES-1]) |-> $past(stage_valid[STAGES-2])); // R3

  AST_PROT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> ($past(key_armed) && $past(wr_en) && ($past(wr_addr) == CMD_ADDR))); // R5

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (key_armed && wr_en && !((wr_addr == KEY_ADDR) && (wr_byte == KEY_VAL))) |=> !key_armed); // R9

  AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:DATA_W] == '0); // R10

endmodule

bind keyed_param_ram ppr_chk #(
  .ADDR_W  (ADDR_W),
  .BUS_W   (BUS_W),
  .DATA_W  (DATA_W),
  .STAGES  (STAGES),
  .KEY_ADDR(KEY_ADDR),
  .CMD_ADDR(CMD_ADDR),
  .KEY_VAL (KEY_VAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_byte    (wr_data[7:0]),
  .rd_data    (rd_data),
  .win_wr     (win_wr),
  .prot_on    (prot_on),
  .key_armed  (key_armed),
  .commit_en  (commit_en),
  .stage_valid(stage_valid)
);

// File: tb/test_keyed_param_ram.sv
module test_keyed_param_ram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;

  always #10 clk = ~clk; // 50 MHz

  keyed_param_ram i_keyed_param_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // Reference state built from the requirements.
  logic [27:0] m_mem [63];
  logic        p1v, p2v;
  int          p1a, p2a;
  logic [27:0] p1d, p2d;
  logic        m_prot, m_arm;

  typedef struct {
    logic [31:0] exp;
    string       req;
    logic [15:0] addr;
  } item_t;
  item_t sb_q [$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h4380) && (a <= 16'h43BE);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 63; i++) m_mem[i] = '0;
    p1v = 0; p2v = 0; p1a = 0; p2a = 0; p1d = '0; p2d = '0;
    m_prot = 0; m_arm = 0;
  endtask

  // Driver: a bus write, with the reference updated alongside.
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [7:0] b;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_en = 1'b0;
    b = d[7:0];
    if (in_win(a) && !m_prot) begin
      if (p2v) m_mem[p2a] = p2d;
      p2v = p1v; p2a = p1a; p2d = p1d;
      p1v = 1'b1; p1a = int'(a - 16'h4380); p1d = d[27:0];
    end
    if (a == 16'hE7FE && b == 8'hAD) begin
      m_arm = 1'b1;
    end else begin
      if (m_arm && a == 16'hE7E3) begin
        if (b == 8'h80) m_prot = 1'b1;
        else if (b == 8'h00) m_prot = 1'b0;
      end
      m_arm = 1'b0;
    end
  endtask

  // Driver: a bus read, expected value pushed to the scoreboard.
  task automatic rd(input logic [15:0] a, input string req);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
    it.exp  = in_win(a) ? {4'h0, m_mem[a - 16'h4380]} : 32'h0;
    it.req  = req;
    it.addr = a;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Monitor: compares each read against the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_en) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "scoreboard-empty", rd_data, 32'h0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(rd_data === it.exp, it.req, rd_data, it.exp);
        end
      end
    end
  end

  // Attempt three locked writes, then read back.
  task automatic try_locked(input string req);
    wr(16'h4388, 32'h9);
    wr(16'h4389, 32'h9);
    wr(16'h438A, 32'h9);
    rd(16'h4384, req);
    rd(16'h4388, req);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hF000_0000 | (32'(i) * 32'h0012_3457);
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset state, R1 window edges
    rd(16'h4380, "R2");
    rd(16'h43A0, "R2");
    rd(16'h43BE, "R2");
    rd(16'h4000, "R1");
    rd(16'h43BF, "R1");

    // R3/R4 two-write commit latency
    wr(16'h4380, 32'h0123_4567);
    rd(16'h4380, "R4");
    wr(16'h4381, 32'h0AAA_5555);
    rd(16'h4380, "R3");
    wr(16'h4382, 32'h0000_0042);
    rd(16'h4380, "R3");
    rd(16'h4381, "R4");

    // R3 non-window writes do not advance the pipeline
    wr(16'h4000, 32'h111);
    wr(16'h43BF, 32'h222);
    wr(16'hE7E3, 32'h00);
    rd(16'h4381, "R3");
    wr(16'h4383, 32'h7);
    rd(16'h4381, "R3");

    // R10 truncation and zero extension
    wr(16'h43BE, 32'hFFFF_FFFF);
    wr(16'h4384, 32'h1);
    wr(16'h4385, 32'h2);
    rd(16'h43BE, "R10");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rd_addr = 16'h43BE;
    #5 check(rd_data === 32'h0, "R10", rd_data, 32'h0);

    // R5 lock, R7 discarded writes and held pipeline, R8 reads while locked
    wr(16'hE7FE, 32'hAD);
    wr(16'hE7E3, 32'h80);
    wr(16'h4384, 32'h0BAD);
    wr(16'h4386, 32'h3);
    wr(16'h4387, 32'h4);
    rd(16'h4384, "R7");
    rd(16'h4386, "R7");
    rd(16'h43BE, "R8");
    rd(16'h4380, "R8");

    // R9 malformed unlock sequences
    wr(16'hE7FE, 32'hAD);
    wr(16'h1234, 32'h0);
    wr(16'hE7E3, 32'h00);
    try_locked("R9");
    wr(16'hE7FE, 32'hAD);
    wr(16'hE7E3, 32'h55);
    wr(16'hE7E3, 32'h00);
    try_locked("R9");
    wr(16'hE7FE, 32'h12AC);
    wr(16'hE7E3, 32'h00);
    try_locked("R9");

    // R6 unlock with idle gap (R9); R7 pending words resume
    wr(16'hE7FE, 32'hAD);
    idle(3);
    wr(16'hE7E3, 32'h00);
    wr(16'h4390, 32'h10);
    rd(16'h4384, "R7");
    wr(16'h4391, 32'h11);
    rd(16'h4385, "R6");

    // R5 relock after a repeated key
    wr(16'hE7FE, 32'hAD);
    wr(16'hE7FE, 32'hAD);
    wr(16'hE7E3, 32'h80);
    wr(16'h4392, 32'h999);
    wr(16'h4393, 32'h999);
    wr(16'h4394, 32'h999);
    rd(16'h4390, "R5");
    rd(16'h4392, "R5");

    // R6 unlock, then fill the whole window
    wr(16'hE7FE, 32'hAD);
    wr(16'hE7E3, 32'h00);
    for (int i = 0; i < 63; i++) wr(16'h4380 + 16'(i), pat(i));
    wr(16'h4380, pat(0));
    wr(16'h4381, pat(1));
    for (int i = 0; i < 63; i++) rd(16'h4380 + 16'(i), "R1");
    rd(16'h43BF, "R1");

    idle(3);
    if (sb_q.size() != 0) check(1'b0, "scoreboard-drain", 32'(sb_q.size()), 32'h0);
    done = 1;
    finish_run();
  end

endmodule